// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel-clock signals for a parallel RGB panel. It also gives the column and row of the current active pixel. Software sets eight geometry fields. Each axis has a sync width, a back porch, an active span and a front porch, and every field is written as its length minus one. A line always runs sync, back porch, active, front porch. A frame runs the same four segments counted in lines. Each control output has its own inversion bit, so the panel sees the polarity it expects.

The dot rate comes from a divider on the source clock. The divider field holds the ratio minus one, and the effective ratio is clamped to 255. When the divide-select bit is clear, or the ratio comes out as one, the divider is bypassed and one pixel passes per source clock. Output runs only while both enables are high: the immediate video enable and the frame enable. Clearing the frame enable lets the frame in progress finish. Clearing the video enable stops output at once. A pending interrupt is raised when the frame enters a selected vertical segment, and a clear pulse removes it.

Top module: `rgb_tgen_top`

## Requirements
- R1: A line consists of hsw_m1+1 sync pixels, then hbp_m1+1 back-porch pixels, then hact_m1+1 active pixels, then hfp_m1+1 front-porch pixels. hsync is active only in the sync part. de is never active during horizontal sync.
- R2: A frame consists of vsw_m1+1 sync lines, then vbp_m1+1 back-porch lines, then vact_m1+1 active lines, then vfp_m1+1 front-porch lines. vsync is active for whole lines of the sync part and starts on the first pixel of a line.
- R3: de is active on active pixels of active lines, giving hact_m1+1 pixels per line and vact_m1+1 lines per frame. While de is active, px_x and px_y count from 0 within the active area. Otherwise both read 0.
- R4: inv_hs, inv_vs, inv_de and inv_pclk each invert their output. An inactive output then rests at 1.
- R5: With div_sel=1 each pixel lasts div_m1+1 source clocks. The divided pixel clock has that period and goes high at the start of each pixel. With div_sel=0, or div_m1=0, each pixel lasts one source clock.
- R6: The effective divide ratio saturates at 255, so div_m1=255 gives pixels of 255 source clocks.
- R7: Output starts only when vid_en and frame_en are both 1. The first frame begins with sync on line 0, pixel 0, in the cycle after both are seen high.
- R8: When vid_en falls, all control outputs go to their inactive level on the next cycle.
- R9: When frame_en falls while running, the current frame completes, including all of its active pixels. Output then stays inactive.
- R10: With irq_en=1, irq is set when the frame enters the vertical segment chosen by irq_sel: 0 sync (frame start), 1 back porch, 2 active, 3 front porch. irq rises in the same cycle as the first line of that segment. With irq_en=0 irq is never set.
- R11: irq stays set until a one-cycle irq_clr pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R12: After reset hsync, vsync, de, pclk_out and irq are 0 (with inversion bits 0), and px_x and px_y are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_en | input | 1 | Immediate video enable |
| frame_en | input | 1 | Enable that stops at frame end |
| hsw_m1 | input | CNT_W | Hsync width minus one |
| hbp_m1 | input | CNT_W | Horizontal back porch minus one |
| hact_m1 | input | CNT_W | Active pixels per line minus one |
| hfp_m1 | input | CNT_W | Horizontal front porch minus one |
| vsw_m1 | input | CNT_W | Vsync width in lines minus one |
| vbp_m1 | input | CNT_W | Vertical back porch minus one |
| vact_m1 | input | CNT_W | Active lines minus one |
| vfp_m1 | input | CNT_W | Vertical front porch minus one |
| inv_hs | input | 1 | Invert hsync |
| inv_vs | input | 1 | Invert vsync |
| inv_de | input | 1 | Invert de |
| inv_pclk | input | 1 | Invert pixel clock |
| div_sel | input | 1 | 1 selects the divided clock |
| div_m1 | input | DIV_W | Divide ratio minus one |
| irq_en | input | 1 | Interrupt enable |
| irq_sel | input | 2 | Vertical segment that raises irq |
| irq_clr | input | 1 | Write-one clear of irq |
| pclk_out | output | 1 | Pixel clock to panel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | CNT_W | Active column |
| px_y | output | CNT_W | Active row |
| irq | output | 1 | Pending frame interrupt |

## Verification
The interrupt set and the software clear can land on the same clock edge. At that edge the set must win. To provoke this, the bench times the clear to the frame period: it finds a vsync rise, counts one frame length minus one cycle, and drives irq_clr for exactly the cycle whose edge opens the next frame. A pass needs irq and vsync both high on the following sample. A plain clear one cycle after a frame start is checked beside it and must give irq low.

// File: rtl/rgb_tgen_pkg.sv
package rgb_tgen_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACT   = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    localparam int NUM_SEG = 4;

    function automatic seg_e seg_after(seg_e s);
        return seg_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/rgb_tgen_clkdiv.sv
module rgb_tgen_clkdiv #(
    parameter int DIV_W     = 8,
    parameter int RATIO_MAX = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div_sel,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick,
    output logic             phase,
    output logic             bypass
);
    localparam int RW = DIV_W + 1;

    typedef struct packed {
        logic [RW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    logic [RW-1:0] ratio_req;
    logic [RW-1:0] ratio;
    logic          at_end;

    always_comb begin
        ratio_req = {1'b0, div_m1} + RW'(1);
        ratio     = (ratio_req > RW'(RATIO_MAX)) ? RW'(RATIO_MAX) : ratio_req;
        bypass    = !div_sel || (ratio <= RW'(1));
        at_end    = (st_q.cnt >= (ratio - RW'(1)));

        st_d = st_q;
        if (!run || bypass) begin
            st_d.cnt = '0;
        end else if (at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + RW'(1);
        end

        tick  = run && (bypass || at_end);
        phase = run && !bypass && (st_q.cnt < (ratio >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rgb_tgen_axis.sv
module rgb_tgen_axis
    import rgb_tgen_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        step,
    input  logic [NUM_SEG-1:0][CNT_W-1:0] len_m1,
    output seg_e                        seg,
    output logic [CNT_W-1:0]            cnt,
    output logic                        at_last,
    output logic [NUM_SEG-1:0]          enter
);
    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
    } ax_st_t;

    ax_st_t st_d, st_q;

    logic       seg_end;
    seg_e       nxt;
    logic [1:0] nxt_idx;

    always_comb begin
        seg_end = (st_q.cnt == len_m1[st_q.seg]);
        nxt     = seg_after(st_q.seg);
        nxt_idx = nxt;
        at_last = seg_end && (st_q.seg == SEG_FRONT);

        st_d = st_q;
        if (clear) begin
            st_d.seg = SEG_SYNC;
            st_d.cnt = '0;
        end else if (step) begin
            if (seg_end) begin
                st_d.seg = nxt;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_enter
        assign enter[i] = step && seg_end && !clear && (nxt_idx == 2'(i));
    end

    assign seg = st_q.seg;
    assign cnt = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{seg: SEG_SYNC, cnt: '0};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rgb_tgen_irq.sv
module rgb_tgen_irq
    import rgb_tgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [1:0]         sel,
    input  logic               start_evt,
    input  logic               run_next,
    input  logic [NUM_SEG-1:0] v_enter,
    input  logic               clr,
    output logic               irq
);
    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    set_evt;

    always_comb begin
        set_evt = en && (((sel == 2'(SEG_SYNC)) && start_evt) ||
                         (run_next && v_enter[sel]));
        st_d = st_q;
        if (set_evt)  st_d.pend = 1'b1;
        else if (clr) st_d.pend = 1'b0;
    end

    assign irq = st_q.pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rgb_tgen_top.sv
module rgb_tgen_top
    import rgb_tgen_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int DIV_W     = 8,
    parameter int RATIO_MAX = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vid_en,
    input  logic             frame_en,
    input  logic [CNT_W-1:0] hsw_m1,
    input  logic [CNT_W-1:0] hbp_m1,
    input  logic [CNT_W-1:0] hact_m1,
    input  logic [CNT_W-1:0] hfp_m1,
    input  logic [CNT_W-1:0] vsw_m1,
    input  logic [CNT_W-1:0] vbp_m1,
    input  logic [CNT_W-1:0] vact_m1,
    input  logic [CNT_W-1:0] vfp_m1,
    input  logic             inv_hs,
    input  logic             inv_vs,
    input  logic             inv_de,
    input  logic             inv_pclk,
    input  logic             div_sel,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             irq_en,
    input  logic [1:0]       irq_sel,
    input  logic             irq_clr,
    output logic             pclk_out,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CNT_W-1:0] px_x,
    output logic [CNT_W-1:0] px_y,
    output logic             irq
);
    typedef struct packed {
        logic running;
    } top_st_t;

    top_st_t st_d, st_q;

    logic tick, phase, bypass;
    logic h_last, v_last, v_step, frame_wrap, start_evt;
    seg_e h_seg, v_seg;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic [NUM_SEG-1:0] h_enter, v_enter;
    logic [NUM_SEG-1:0][CNT_W-1:0] h_len, v_len;
    logic hs_raw, vs_raw, de_raw, pclk_raw;

    assign h_len = {hfp_m1, hact_m1, hbp_m1, hsw_m1};
    assign v_len = {vfp_m1, vact_m1, vbp_m1, vsw_m1};

    rgb_tgen_clkdiv #(
        .DIV_W    (DIV_W),
        .RATIO_MAX(RATIO_MAX)
    ) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.running),
        .div_sel(div_sel),
        .div_m1 (div_m1),
        .tick   (tick),
        .phase  (phase),
        .bypass (bypass)
    );

    rgb_tgen_axis #(.CNT_W(CNT_W)) i_hax (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!st_q.running),
        .step   (tick),
        .len_m1 (h_len),
        .seg    (h_seg),
        .cnt    (h_cnt),
        .at_last(h_last),
        .enter  (h_enter)
    );

    assign v_step = tick && h_last;

    rgb_tgen_axis #(.CNT_W(CNT_W)) i_vax (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!st_q.running),
        .step   (v_step),
        .len_m1 (v_len),
        .seg    (v_seg),
        .cnt    (v_cnt),
        .at_last(v_last),
        .enter  (v_enter)
    );

    always_comb begin
        frame_wrap = v_step && v_last;
        start_evt  = !st_q.running && vid_en && frame_en;

        st_d = st_q;
        if (!vid_en)                        st_d.running = 1'b0;
        else if (!st_q.running)             st_d.running = frame_en;
        else if (!frame_en && frame_wrap)   st_d.running = 1'b0;
        else                                st_d.running = 1'b1;
    end

    rgb_tgen_irq i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (irq_en),
        .sel      (irq_sel),
        .start_evt(start_evt),
        .run_next (st_d.running),
        .v_enter  (v_enter),
        .clr      (irq_clr),
        .irq      (irq)
    );

    always_comb begin
        hs_raw   = st_q.running && (h_seg == SEG_SYNC);
        vs_raw   = st_q.running && (v_seg == SEG_SYNC);
        de_raw   = st_q.running && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
        pclk_raw = st_q.running && (bypass ? clk : phase);
        hsync    = hs_raw ^ inv_hs;
        vsync    = vs_raw ^ inv_vs;
        de       = de_raw ^ inv_de;
        pclk_out = pclk_raw ^ inv_pclk;
        px_x     = de_raw ? h_cnt : '0;
        px_y     = de_raw ? v_cnt : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rgb_tgen_chk.sv
module rgb_tgen_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vid_en,
    input logic             inv_hs,
    input logic             inv_vs,
    input logic             inv_de,
    input logic             irq_en,
    input logic             irq_clr,
    input logic [CNT_W-1:0] hact_m1,
    input logic [CNT_W-1:0] vact_m1,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic [CNT_W-1:0] px_x,
    input logic [CNT_W-1:0] px_y,
    input logic             irq
);

    p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |=> (hsync == inv_hs) && (vsync == inv_vs) && (de == inv_de));

    p_sync_de_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync != inv_hs) |-> (de == inv_de));

    p_px_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (de == inv_de) |-> (px_x == '0) && (px_y == '0));

    p_px_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (de != inv_de) |-> (px_x <= hact_m1) && (px_y <= vact_m1));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !irq_en) |=> !irq);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

endmodule

bind rgb_tgen_top rgb_tgen_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_rgb_tgen_top.sv
`timescale 1ns/1ps
module test_rgb_tgen_top;
    localparam int CW = 12;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vid_en = 0, frame_en = 0;
    logic [CW-1:0] hsw_m1 = 0, hbp_m1 = 0, hact_m1 = 0, hfp_m1 = 0;
    logic [CW-1:0] vsw_m1 = 0, vbp_m1 = 0, vact_m1 = 0, vfp_m1 = 0;
    logic inv_hs = 0, inv_vs = 0, inv_de = 0, inv_pclk = 0;
    logic div_sel = 0;
    logic [DW-1:0] div_m1 = 0;
    logic irq_en = 0, irq_clr = 0;
    logic [1:0] irq_sel = 0;
    logic pclk_out, hsync, vsync, de, irq;
    logic [CW-1:0] px_x, px_y;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        string req;
        string what;
        int    val;
    } exp_t;
    exp_t exp_q[$];

    localparam int S_HS = 0, S_VS = 1, S_DE = 2, S_PC = 3, S_IRQ = 4;

    always #4 clk = ~clk;

    rgb_tgen_top #(.CNT_W(CW), .DIV_W(DW), .RATIO_MAX(255)) i_rgb_tgen_top (.*);

    function automatic bit sig(int s);
        case (s)
            S_HS:    return hsync ^ inv_hs;
            S_VS:    return vsync ^ inv_vs;
            S_DE:    return de ^ inv_de;
            S_PC:    return pclk_out ^ inv_pclk;
            default: return irq;
        endcase
    endfunction

    // driver side: push an expected item
    task automatic expect_item(string req, string what, int val);
        exp_t e;
        e.req = req; e.what = what; e.val = val;
        exp_q.push_back(e);
    endtask

    // monitor side: pop and compare
    task automatic observe(int actual);
        exp_t e;
        if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard empty: actual %0d expected none", actual);
            return;
        end
        e = exp_q.pop_front();
        n_cmp++;
        if (actual != e.val) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", e.req, e.what, actual, e.val);
        end
    endtask

    task automatic measure(int s, output int hi, output int per);
        int lo;
        hi = 0; lo = 0;
        while (sig(s) != 1'b0) @(negedge clk);
        while (sig(s) == 1'b0) @(negedge clk);
        while (sig(s) == 1'b1) begin hi++; @(negedge clk); end
        while (sig(s) == 1'b0) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    task automatic wait_rise(int s);
        bit prev;
        prev = sig(s);
        forever begin
            @(negedge clk);
            if (!prev && sig(s)) break;
            prev = sig(s);
        end
    endtask

    task automatic count_high(int s, int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (sig(s)) c++;
            @(negedge clk);
        end
    endtask

    task automatic stop_run();
        @(negedge clk);
        vid_en = 0; frame_en = 0;
        @(negedge clk);
    endtask

    task automatic start_run();
        vid_en = 1; frame_en = 1;
        @(negedge clk);
    endtask

    // line: 2+3+4+2 = 11 pixels; frame: 1+2+3+1 = 7 lines
    task automatic cfg_a();
        hsw_m1 = 1; hbp_m1 = 2; hact_m1 = 3; hfp_m1 = 1;
        vsw_m1 = 0; vbp_m1 = 1; vact_m1 = 2; vfp_m1 = 0;
    endtask

    initial begin
        #1200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, per, c, n, first_de, de_rises, hs_rises, max_x, max_y;
        bit prev_de, prev_hs;

        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        expect_item("R12", "hsync", 0); observe(hsync);
        expect_item("R12", "vsync", 0); observe(vsync);
        expect_item("R12", "de", 0);    observe(de);
        expect_item("R12", "irq", 0);   observe(irq);
        expect_item("R12", "pclk", 0);  observe(pclk_out);
        expect_item("R12", "px_x", 0);  observe(px_x);

        cfg_a();
        div_sel = 0; div_m1 = 2;      // R5: ratio field ignored without div_sel
        // R7: vid_en alone does not start
        vid_en = 1; frame_en = 0;
        @(negedge clk);
        count_high(S_HS, 20, c);
        expect_item("R7", "hsync cycles with frame_en low", 0); observe(c);
        frame_en = 1;
        @(negedge clk);
        expect_item("R7", "vsync on first cycle", 1); observe(sig(S_VS));
        expect_item("R7", "hsync on first cycle", 1); observe(sig(S_HS));

        // R1 and R5 bypass
        expect_item("R1", "hsync width", 2);
        expect_item("R1", "line period", 11);
        measure(S_HS, hi, per); observe(hi); observe(per);
        // R2
        expect_item("R2", "vsync width", 11);
        expect_item("R2", "frame period", 77);
        measure(S_VS, hi, per); observe(hi); observe(per);
        // R1, R2, R3 over one frame
        wait_rise(S_VS);
        first_de = -1; de_rises = 0; hs_rises = 0; max_x = 0; max_y = 0;
        prev_de = 0; prev_hs = 0;
        for (int k = 0; k < 77; k++) begin
            if (sig(S_DE) && !prev_de) begin
                de_rises++;
                if (first_de < 0) first_de = k;
            end
            if (sig(S_HS) && !prev_hs) hs_rises++;
            if (sig(S_DE)) begin
                if (int'(px_x) > max_x) max_x = int'(px_x);
                if (int'(px_y) > max_y) max_y = int'(px_y);
            end
            prev_de = sig(S_DE); prev_hs = sig(S_HS);
            @(negedge clk);
        end
        expect_item("R2", "first de offset", 38);    observe(first_de);
        expect_item("R3", "active lines", 3);        observe(de_rises);
        expect_item("R2", "lines per frame", 7);     observe(hs_rises);
        expect_item("R3", "last px_x", 3);           observe(max_x);
        expect_item("R3", "last px_y", 2);           observe(max_y);
        wait_rise(S_DE);
        expect_item("R3", "px_x at de start", 0);    observe(px_x);
        expect_item("R3", "de width", 4);
        measure(S_DE, hi, per); observe(hi);

        // R8 immediate stop
        wait_rise(S_VS);
        vid_en = 0;
        @(negedge clk);
        expect_item("R8", "vsync after vid_en low", 0); observe(vsync);
        expect_item("R8", "hsync after vid_en low", 0); observe(hsync);

        // R4 polarity
        frame_en = 0;
        inv_hs = 1; inv_vs = 1; inv_de = 1; inv_pclk = 1;
        @(negedge clk);
        expect_item("R4", "idle hsync", 1); observe(hsync);
        expect_item("R4", "idle vsync", 1); observe(vsync);
        expect_item("R4", "idle de", 1);    observe(de);
        expect_item("R4", "idle pclk", 1);  observe(pclk_out);
        start_run();
        expect_item("R4", "inverted hsync width", 2);
        measure(S_HS, hi, per); observe(hi);
        expect_item("R4", "inverted de width", 4);
        measure(S_DE, hi, per); observe(hi);
        stop_run();
        inv_hs = 0; inv_vs = 0; inv_de = 0; inv_pclk = 0;

        // R5 divided clock
        div_sel = 1; div_m1 = 2;
        start_run();
        expect_item("R5", "hsync width at ratio 3", 6);
        expect_item("R5", "line period at ratio 3", 33);
        measure(S_HS, hi, per); observe(hi); observe(per);
        expect_item("R5", "pclk high", 1);
        expect_item("R5", "pclk period", 3);
        measure(S_PC, hi, per); observe(hi); observe(per);
        stop_run();
        div_m1 = 0;
        start_run();
        expect_item("R5", "hsync width at field 0", 2);
        measure(S_HS, hi, per); observe(hi);
        stop_run();

        // R6 saturation
        div_m1 = 255;
        start_run();
        expect_item("R6", "pclk period saturated", 255);
        measure(S_PC, hi, per); observe(per);
        expect_item("R6", "hsync width saturated", 510);
        measure(S_HS, hi, per); observe(hi);
        stop_run();
        div_sel = 0; div_m1 = 0;

        // R10 / R11 interrupt, sync select
        irq_en = 1; irq_sel = 0;
        start_run();
        wait_rise(S_VS);
        expect_item("R10", "irq at frame start", 1); observe(irq);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        expect_item("R11", "irq after clear", 0); observe(irq);
        repeat (75) @(negedge clk);
        irq_clr = 1;                       // edge that opens the next frame
        @(negedge clk);
        irq_clr = 0;
        expect_item("R11", "set wins over clear", 1); observe(irq);
        expect_item("R2", "next frame vsync", 1);     observe(sig(S_VS));

        // R10 active select
        irq_sel = 2;
        wait_rise(S_VS);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        n = 1;
        while (!irq && n < 200) begin @(negedge clk); n++; end
        expect_item("R10", "irq offset active select", 33); observe(n);

        // R10 disabled
        irq_en = 0;
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        count_high(S_IRQ, 100, c);
        expect_item("R10", "irq cycles while disabled", 0); observe(c);

        // R9 frame-boundary stop
        wait_rise(S_VS);
        repeat (10) @(negedge clk);
        frame_en = 0;
        count_high(S_DE, 67, c);
        expect_item("R9", "de pixels finishing frame", 12); observe(c);
        count_high(S_HS, 100, c);
        expect_item("R9", "hsync after frame end", 0); observe(c);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule